// File: doc/BRIEF.md
# Transmit Done Indication Timer

This block times the two end-of-burst indications of a transmitter: a "transmit done" pulse that follows the last data symbol and a "last tail" pulse that follows the last tail symbol. A framing engine reports each of those events with a one-cycle strobe. The timer delays each indication so that it lines up with the moment the symbol actually leaves the pulse-shaping filter.

A configuration bit picks one of two timing schemes. In the precise scheme, the delay is programmable in steps of 1.2 symbol times. It is counted on a sub-symbol tick that runs at five ticks per symbol, so one step is six ticks and the indication lands within one tick of its ideal time. In the legacy scheme, the programmed delay is ignored and the indication fires on the fourth symbol strobe after the event. A second configuration bit reports the receive sample delay that the current scheme implies.

The same timer also starts the end-of-transmit sequence. When the framer arms it, the framer supplies the number of symbols left before the default start time. A programmable offset pulls the start earlier by a whole number of symbols.

Top module: `tx_done_timer`

## Requirements
- R1: After reset, `done_pulse`, `tail_pulse` and `end_start` are 0, `cfg_rdata` reads 16'hFFFC and `rx_smp_dly` is 6.
- R2: A write stores bit 0 (receive delay select) and bit 1 (indication legacy select) of `cfg_wdata`. In `cfg_rdata`, bits 15 to 2 always read as 1, whatever was written, and bits 1:0 return the stored bits from the cycle after the write.
- R3: With bit 1 = 0 and `done_dly` = N > 0, `done_pulse` rises exactly 6*N ticks after `last_data_evt`. The event is sampled at one clock edge, and the pulse appears after the edge that carries the 6*N-th tick.
- R4: With bit 1 = 0 and `done_dly` = 0, the indication appears in the cycle right after the event.
- R5: With bit 1 = 1, `tick` and `done_dly` have no effect. The indication appears after the edge that carries the fourth `sym_stb` following the event.
- R6: Each indication is high for exactly one clock cycle.
- R7: A new event that arrives while an indication is pending restarts its countdown. This holds even in the cycle where the pending countdown would have expired, and in that case no pulse is given for the earlier event.
- R8: `last_tail_evt` drives `tail_pulse` under the same rules as R3 to R7. It is independent of the done path, so it never raises `done_pulse`.
- R9: After `end_arm` with `end_dist` = D and `end_ofs` = O < D, `end_start` appears after the edge that carries the (D-O)-th following `sym_stb`.
- R10: If `end_ofs` >= `end_dist` at `end_arm`, `end_start` appears in the next cycle.
- R11: `rx_smp_dly` is 6 ticks (1.2 symbols) when stored bit 0 = 0, and 41 ticks (8.2 symbols) when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data, reserved bits read as 1 |
| done_dly | input | 8 | Indication delay in units of 6 ticks |
| end_ofs | input | 8 | Symbols by which the end sequence starts early |
| end_dist | input | 8 | Symbols from `end_arm` to the default end sequence start |
| tick | input | 1 | Sub-symbol tick, 5 per symbol |
| sym_stb | input | 1 | Symbol strobe |
| last_data_evt | input | 1 | Last data symbol event |
| last_tail_evt | input | 1 | Last tail symbol event |
| end_arm | input | 1 | Arms the end sequence start countdown |
| done_pulse | output | 1 | Transmit done indication |
| tail_pulse | output | 1 | Last tail indication |
| end_start | output | 1 | End-of-transmit sequence start pulse |
| rx_smp_dly | output | 6 | Receive sample delay in ticks |

## Verification
The subtle collision is a fresh event landing in the very cycle in which a pending countdown takes its final step. The restart must win, and the old indication must be dropped. The bench provokes this by placing a second `last_data_evt` exactly twelve ticks after the first, with a delay of two units. It then judges that no pulse appears in that window and that the single pulse arrives twelve ticks after the second event. A second overlap comes from ticks that keep running while legacy mode is selected. Here the bench confirms that no pulse appears until the fourth symbol strobe.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
  typedef struct packed {
    logic ind_legacy;  // bit 1: legacy indication timing
    logic rx_legacy;   // bit 0: legacy receive sample delay
  } tdi_cfg_t;

  localparam int CFG_W  = 16;
  localparam int CFG_USED = 2;
endpackage

// File: rtl/tdi_cfg_reg.sv
module tdi_cfg_reg
  import tdi_pkg::*;
#(
  parameter int RXD_W        = 6,
  parameter int RX_MIN_TICKS = 6,
  parameter int RX_LEG_TICKS = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output tdi_cfg_t         cfg,
  output logic [RXD_W-1:0] rx_dly
);
  localparam int RESV_W = CFG_W - CFG_USED;

  tdi_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = tdi_cfg_t'(wdata[CFG_USED-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg    = cfg_q;
  assign rdata  = {{RESV_W{1'b1}}, cfg_q};
  assign rx_dly = cfg_q.rx_legacy ? RXD_W'(RX_LEG_TICKS) : RXD_W'(RX_MIN_TICKS);
endmodule

// File: rtl/tdi_countdown.sv
module tdi_countdown #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             fire_q, fire_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    fire_d = 1'b0;
    if (load) begin
      if (load_val == '0) begin
        pend_d = 1'b0;
        fire_d = 1'b1;
      end else begin
        cnt_d  = load_val;
        pend_d = 1'b1;
      end
    end else if (pend_q && step) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_d  = '0;
        pend_d = 1'b0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_en = load | (pend_q & step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end

  assign fire = fire_q;
endmodule

// File: rtl/tx_done_timer.sv
module tx_done_timer
  import tdi_pkg::*;
#(
  parameter int DLY_W        = 8,
  parameter int SYM_W        = 8,
  parameter int UNIT_TICKS   = 6,
  parameter int LEGACY_SYMS  = 4,
  parameter int RXD_W        = 6,
  parameter int RX_MIN_TICKS = 6,
  parameter int RX_LEG_TICKS = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic [DLY_W-1:0] done_dly,
  input  logic [SYM_W-1:0] end_ofs,
  input  logic [SYM_W-1:0] end_dist,
  input  logic             tick,
  input  logic             sym_stb,
  input  logic             last_data_evt,
  input  logic             last_tail_evt,
  input  logic             end_arm,
  output logic             done_pulse,
  output logic             tail_pulse,
  output logic             end_start,
  output logic [RXD_W-1:0] rx_smp_dly
);
  localparam int UNIT_W = $clog2(UNIT_TICKS + 1);
  localparam int CNT_W  = (DLY_W + UNIT_W > SYM_W) ? DLY_W + UNIT_W : SYM_W;
  localparam int N_IND  = 2;

  tdi_cfg_t         cfg;
  logic [CNT_W-1:0] ind_load_val;
  logic             ind_step;
  logic [CNT_W-1:0] end_load_val;
  logic [N_IND-1:0] ind_evt;
  logic [N_IND-1:0] ind_fire;

  tdi_cfg_reg #(
    .RXD_W        (RXD_W),
    .RX_MIN_TICKS (RX_MIN_TICKS),
    .RX_LEG_TICKS (RX_LEG_TICKS)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .cfg    (cfg),
    .rx_dly (rx_smp_dly)
  );

  // Delay and step source shared by both indication paths.
  always_comb begin
    if (cfg.ind_legacy) begin
      ind_load_val = CNT_W'(LEGACY_SYMS);
      ind_step     = sym_stb;
    end else begin
      ind_load_val = CNT_W'(done_dly) * CNT_W'(UNIT_TICKS);
      ind_step     = tick;
    end
  end

  assign ind_evt = {last_tail_evt, last_data_evt};

  for (genvar g = 0; g < N_IND; g++) begin : g_ind
    tdi_countdown #(.CNT_W(CNT_W)) u_cd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ind_evt[g]),
      .load_val (ind_load_val),
      .step     (ind_step),
      .fire     (ind_fire[g])
    );
  end

  assign done_pulse = ind_fire[0];
  assign tail_pulse = ind_fire[1];

  // Offset pulls the start earlier; a saturated offset fires at once.
  always_comb begin
    if (end_ofs >= end_dist) end_load_val = '0;
    else                     end_load_val = CNT_W'(end_dist - end_ofs);
  end

  tdi_countdown #(.CNT_W(CNT_W)) u_end (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (end_arm),
    .load_val (end_load_val),
    .step     (sym_stb),
    .fire     (end_start)
  );
endmodule

// File: rtl/tx_done_timer_chk.sv
module tx_done_timer_chk #(
  parameter int DLY_W = 8,
  parameter int SYM_W = 8,
  parameter int RXD_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [15:0]      cfg_wdata,
  input logic [15:0]      cfg_rdata,
  input logic [DLY_W-1:0] done_dly,
  input logic [SYM_W-1:0] end_ofs,
  input logic [SYM_W-1:0] end_dist,
  input logic             tick,
  input logic             sym_stb,
  input logic             last_data_evt,
  input logic             last_tail_evt,
  input logic             end_arm,
  input logic             done_pulse,
  input logic             tail_pulse,
  input logic             end_start,
  input logic [RXD_W-1:0] rx_smp_dly
);
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[1:0] == $past(cfg_wdata[1:0]));

  p_rx_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_smp_dly == (cfg_rdata[0] ? RXD_W'(41) : RXD_W'(6)));

  p_done_needs_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(last_data_evt) || $past(tick) || $past(sym_stb));

  p_legacy_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[1] && last_data_evt) |=> !done_pulse);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[1] && last_data_evt && done_dly != '0) |=> !done_pulse);

  p_tail_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[1] && last_tail_evt && done_dly != '0) |=> !tail_pulse);

  p_end_at_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_arm && end_ofs >= end_dist) |=> end_start);
endmodule

bind tx_done_timer tx_done_timer_chk #(.DLY_W(DLY_W), .SYM_W(SYM_W), .RXD_W(RXD_W)) u_chk (.*);

// File: tb/tx_done_timer_bench.sv
module tx_done_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic [7:0]  done_dly;
  logic [7:0]  end_ofs;
  logic [7:0]  end_dist;
  logic        tick;
  logic        sym_stb;
  logic        last_data_evt;
  logic        last_tail_evt;
  logic        end_arm;
  logic        done_pulse;
  logic        tail_pulse;
  logic        end_start;
  logic [5:0]  rx_smp_dly;

  int errs;
  int checks;

  tx_done_timer u_tx_done_timer (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Called at a negedge; raises the event there and counts negedges to the pulse.
  task automatic measure(input int sel, input int lim, output int k, output int other);
    if (sel == 0) last_data_evt = 1'b1; else last_tail_evt = 1'b1;
    k = 0; other = 0;
    forever begin
      @(negedge clk);
      last_data_evt = 1'b0; last_tail_evt = 1'b0;
      k++;
      if ((sel == 0 ? tail_pulse : done_pulse) == 1'b1) other = 1;
      if ((sel == 0 ? done_pulse : tail_pulse) == 1'b1) break;
      if (k > lim) break;
    end
  endtask

  task automatic stb_obs(output logic d, output logic e);
    @(negedge clk); sym_stb = 1'b1;
    @(negedge clk); sym_stb = 1'b0;
    d = done_pulse; e = end_start;
  endtask

  task automatic t_reset;
    chk("R1 done", done_pulse, 0);
    chk("R1 tail", tail_pulse, 0);
    chk("R1 end", end_start, 0);
    chk("R1 rdata", cfg_rdata, 16'hFFFC);
    chk("R1 rxdly", rx_smp_dly, 6);
  endtask

  task automatic t_cfg;
    cfg_write(16'h0000);
    chk("R2 rdata zero write", cfg_rdata, 16'hFFFC);
    cfg_write(16'h0003);
    chk("R2 rdata low bits", cfg_rdata, 16'hFFFF);
    chk("R11 legacy rx delay", rx_smp_dly, 41);
    cfg_write(16'h5A50);
    chk("R2 reserved ignored", cfg_rdata, 16'hFFFC);
    chk("R11 minimal rx delay", rx_smp_dly, 6);
  endtask

  task automatic t_delay;
    int k, o;
    done_dly = 8'd3;
    @(negedge clk); measure(0, 40, k, o);
    chk("R3 delay 3 units", k, 19);
    @(negedge clk);
    chk("R6 single cycle", done_pulse, 0);
    done_dly = 8'd1;
    measure(0, 40, k, o);
    chk("R3 delay 1 unit", k, 7);
    done_dly = 8'd0;
    @(negedge clk); measure(0, 40, k, o);
    chk("R4 zero delay", k, 1);
    @(negedge clk);
    chk("R6 zero delay single", done_pulse, 0);
  endtask

  task automatic t_tail;
    int k, o;
    done_dly = 8'd2;
    @(negedge clk); measure(1, 40, k, o);
    chk("R8 tail delay", k, 13);
    chk("R8 no done from tail", o, 0);
    @(negedge clk);
    chk("R8 tail single", tail_pulse, 0);
  endtask

  task automatic t_retrig;
    int k, o;
    int seen;
    done_dly = 8'd2;
    seen = 0;
    @(negedge clk);
    last_data_evt = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      last_data_evt = 1'b0;
      if (done_pulse) seen = 1;
    end
    measure(0, 40, k, o);
    chk("R7 no pulse before restart", seen, 0);
    chk("R7 restart at expiry", k, 13);
  endtask

  task automatic t_legacy;
    logic d, e;
    int seen;
    cfg_write(16'h0002);
    done_dly = 8'd1;
    seen = 0;
    @(negedge clk); last_data_evt = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      last_data_evt = 1'b0;
      if (done_pulse) seen = 1;
    end
    chk("R5 ticks ignored", seen, 0);
    for (int i = 1; i <= 3; i++) begin
      stb_obs(d, e);
      chk("R5 before fourth strobe", d, 0);
    end
    stb_obs(d, e);
    chk("R5 fourth strobe", d, 1);
    @(negedge clk);
    chk("R6 legacy single", done_pulse, 0);
    cfg_write(16'h0000);
  endtask

  task automatic t_end;
    logic d, e;
    end_dist = 8'd6; end_ofs = 8'd2;
    @(negedge clk); end_arm = 1'b1;
    @(negedge clk); end_arm = 1'b0;
    chk("R9 not at once", end_start, 0);
    for (int i = 1; i <= 3; i++) begin
      stb_obs(d, e);
      chk("R9 before count", e, 0);
    end
    stb_obs(d, e);
    chk("R9 dist minus offset", e, 1);
    end_ofs = 8'd9;
    @(negedge clk); end_arm = 1'b1;
    @(negedge clk); end_arm = 1'b0;
    chk("R10 offset beyond", end_start, 1);
    end_ofs = 8'd6;
    @(negedge clk); end_arm = 1'b1;
    @(negedge clk); end_arm = 1'b0;
    chk("R10 offset equal", end_start, 1);
    @(negedge clk);
    chk("R10 single", end_start, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    errs = 0; checks = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    done_dly = '0; end_ofs = '0; end_dist = '0;
    tick = 1'b1; sym_stb = 1'b0;
    last_data_evt = 1'b0; last_tail_evt = 1'b0; end_arm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_delay();
    t_tail();
    t_retrig();
    t_legacy();
    t_end();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule